// File: doc/BRIEF.md
# Privileged Control Register and Trap Unit

This unit keeps the privileged control state of a small in-order core: a status word, the exception PC, the trap vector, the trap cause, the faulting address, a free-running count with its compare value, a page-table base, two scratch words and a pair of host mailbox words. Software reaches them through one indexed access port. A read returns the addressed register at once. A write commits on the next clock edge, and in the cycle it is issued the port returns the value the register held before the write.

Three interrupt sources (timer, inter-processor, host) record pending bits inside the status word, where software writes cannot change them. Each cycle the unit ANDs pending with the status mask, gates the result with the global enable and picks the lowest-numbered source. An exception reported by the pipeline takes priority over an interrupt, and at most one trap is entered per cycle. On trap entry the unit enters supervisor mode, shadows the old privilege and enable bits, latches cause and exception PC, loads the PC from the trap vector and releases any load reservation. It also emits a TLB-flush strobe and an outbound IPI request. The pipeline, MMU and messaging fabric lie outside the block.

Top module: `priv_ctrl`

## Requirements
- R1: After reset the status word is 0x81: supervisor bit 0 set, plus 64-bit-supervisor bit 7 when 64-bit support is configured (default). PC is 0x2000. Trap vector, exception PC, faulting address, cause, count and compare read 0, and no trap is signalled.
- R2: Status layout: bit 0 supervisor, 1 previous supervisor, 2 interrupt enable, 3 previous enable, 4 FPU enable, 5 vector enable, 6 user 64-bit, 7 supervisor 64-bit, bits 23:16 interrupt mask, and an 8-bit pending field at PEND_LSB (default 24). A status write stores bits 7:0 and 23:16 and keeps the pending field. It zeroes bits of unconfigured features (vector by default), reads all other bits as zero and asserts `tlb_flush_o` in the write cycle.
- R3: The interrupt request is pending AND mask, gated by interrupt enable. Sources are timer 0, IPI 1 and host 2, and the lowest-numbered request is taken.
- R4: An interrupt's cause is its number with bit 63 set when status bit 7 is set, otherwise with bit 31 set.
- R5: On trap entry the supervisor bit is set and interrupt enable cleared. The previous-supervisor bit takes the old supervisor bit and the previous-enable bit takes the old enable. The cause and exception PC are latched, where an interrupt saves the current PC. The PC is loaded from the trap vector and `resv_release_o` pulses.
- R6: An exception and an eligible interrupt in the same cycle enter only the exception, with its own cause, PC and, when flagged, faulting address.
- R7: When count advances by N, the timer pending bit is raised if old count < compare and old count + N >= compare. A compare write clears that bit and wins over a raise in the same cycle.
- R8: A page-table base write clears the bits below the page size (13 bits by default). A write to the clear-IPI register sets the IPI pending bit when data bit 0 is 1 and clears it when bit 0 is 0.
- R9: A to-host write takes effect only while the register holds zero.
- R10: A from-host write stores the value and sets the host pending bit exactly when the value is nonzero.
- R11: The address-space-ID register reads 0, the implementation register 1 and the core-ID register HART_IDX (default 3). The flush-on-read register reads 0 and asserts `tlb_flush_o` when read. Any unassigned index reads all ones.
- R12: Indices: status 0, exception PC 1, faulting address 2, trap vector 3, count 4, compare 5, cause 6, page-table base 7, address-space ID 8, flush-on-read 9, core ID 10, implementation 11, scratch 12 and 13, IPI send 14, clear-IPI 15, to-host 16, from-host 17. A write returns the pre-write value on `acc_rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_idx_i | input | 5 | Register index |
| acc_rd_i | input | 1 | Read strobe (side effects only) |
| acc_wr_i | input | 1 | Write strobe |
| acc_wdata_i | input | XLEN | Write data |
| acc_rdata_o | output | XLEN | Current value of the indexed register |
| cnt_inc_i | input | INC_W | Count advance this cycle |
| ipi_set_i | input | 1 | Incoming inter-processor interrupt |
| pc_adv_i | input | 1 | Load PC from npc_i |
| npc_i | input | XLEN | Next PC from the pipeline |
| pc_o | output | XLEN | Current PC |
| exc_valid_i | input | 1 | Exception request |
| exc_cause_i | input | XLEN | Exception cause |
| exc_pc_i | input | XLEN | PC of the faulting instruction |
| exc_badaddr_valid_i | input | 1 | Faulting address is valid |
| exc_badaddr_i | input | XLEN | Faulting address |
| trap_taken_o | output | 1 | A trap is entered this cycle |
| trap_cause_o | output | XLEN | Cause of that trap |
| resv_release_o | output | 1 | Release load reservation |
| tlb_flush_o | output | 1 | TLB flush strobe |
| ipi_send_o | output | 1 | Outbound IPI request |
| ipi_send_data_o | output | XLEN | Outbound IPI target data |
| tohost_o | output | XLEN | To-host mailbox value |

## Verification
Exception entry and interrupt entry can fall in the same cycle. The bench first writes the status word so that enable, mask and a pending IPI line up, which makes the interrupt eligible on the next cycle. It then raises an exception in exactly that cycle. It judges the result by the trap cause presented that cycle, and afterwards by the exception PC, cause and faulting address read back, all of which must show the exception and none the interrupt.

// File: rtl/priv_pkg.sv
package priv_pkg;
  localparam int IDX_W = 5;
  localparam logic [IDX_W-1:0] IDX_STATUS   = 5'd0;
  localparam logic [IDX_W-1:0] IDX_EPC      = 5'd1;
  localparam logic [IDX_W-1:0] IDX_BADADDR  = 5'd2;
  localparam logic [IDX_W-1:0] IDX_TVEC     = 5'd3;
  localparam logic [IDX_W-1:0] IDX_COUNT    = 5'd4;
  localparam logic [IDX_W-1:0] IDX_CMP      = 5'd5;
  localparam logic [IDX_W-1:0] IDX_CAUSE    = 5'd6;
  localparam logic [IDX_W-1:0] IDX_PTBASE   = 5'd7;
  localparam logic [IDX_W-1:0] IDX_ASID     = 5'd8;
  localparam logic [IDX_W-1:0] IDX_FLUSHRD  = 5'd9;
  localparam logic [IDX_W-1:0] IDX_HART     = 5'd10;
  localparam logic [IDX_W-1:0] IDX_IMPL     = 5'd11;
  localparam logic [IDX_W-1:0] IDX_SCR0     = 5'd12;
  localparam logic [IDX_W-1:0] IDX_SCR1     = 5'd13;
  localparam logic [IDX_W-1:0] IDX_IPI_SEND = 5'd14;
  localparam logic [IDX_W-1:0] IDX_IPI_CLR  = 5'd15;
  localparam logic [IDX_W-1:0] IDX_TOHOST   = 5'd16;
  localparam logic [IDX_W-1:0] IDX_FROMHOST = 5'd17;

  localparam int SR_W        = 32;
  localparam int ST_SUP      = 0;
  localparam int ST_PSUP     = 1;
  localparam int ST_IE       = 2;
  localparam int ST_PIE      = 3;
  localparam int ST_FP       = 4;
  localparam int ST_VEC      = 5;
  localparam int ST_U64      = 6;
  localparam int ST_S64      = 7;
  localparam int ST_MASK_LSB = 16;

  localparam int IRQ_W     = 8;
  localparam int IRQ_TIMER = 0;
  localparam int IRQ_IPI   = 1;
  localparam int IRQ_HOST  = 2;
endpackage

// File: rtl/priv_irq_sel.sv
module priv_irq_sel #(
  parameter int N = 8,
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [SEL_W-1:0] sel_o
);
  assign valid_o = |req_i;

  // lowest index wins
  always_comb begin
    sel_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) sel_o = SEL_W'(i);
    end
  end
endmodule

// File: rtl/priv_timer.sv
module priv_timer #(
  parameter int CNT_W = 32,
  parameter int INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_wr_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] compare_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] count_q, cmp_q;
  logic [CNT_W:0]   sum_w;

  assign sum_w  = {1'b0, count_q} + (CNT_W+1)'(inc_i);
  assign fire_o = !cnt_wr_i && (count_q < cmp_q) && (sum_w >= {1'b0, cmp_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      cmp_q   <= '0;
    end else begin
      if (cnt_wr_i) count_q <= wdata_i;
      else          count_q <= sum_w[CNT_W-1:0];
      if (cmp_wr_i) cmp_q <= wdata_i;
    end
  end

  assign count_o   = count_q;
  assign compare_o = cmp_q;
endmodule

// File: rtl/priv_status.sv
module priv_status
  import priv_pkg::*;
#(
  parameter bit HAS_64   = 1'b1,
  parameter bit HAS_FPU  = 1'b1,
  parameter bit HAS_VEC  = 1'b0,
  parameter int PEND_LSB = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SR_W-1:0]  wdata_i,
  input  logic [IRQ_W-1:0] pend_set_i,
  input  logic [IRQ_W-1:0] pend_clr_i,
  input  logic             trap_i,
  output logic [SR_W-1:0]  sr_o
);
  localparam logic [SR_W-1:0] ONE       = SR_W'(1);
  localparam logic [SR_W-1:0] CTRL_BITS = SR_W'(8'hFF) | (SR_W'(8'hFF) << ST_MASK_LSB);
  localparam logic [SR_W-1:0] DROP_64   = HAS_64  ? '0 : ((ONE << ST_U64) | (ONE << ST_S64));
  localparam logic [SR_W-1:0] DROP_FP   = HAS_FPU ? '0 : (ONE << ST_FP);
  localparam logic [SR_W-1:0] DROP_VEC  = HAS_VEC ? '0 : (ONE << ST_VEC);
  localparam logic [SR_W-1:0] WMASK     = CTRL_BITS & ~(DROP_64 | DROP_FP | DROP_VEC);
  localparam logic [SR_W-1:0] RST_VAL   = (ONE << ST_SUP) | (HAS_64 ? (ONE << ST_S64) : '0);

  logic [SR_W-1:0]  sr_q, ctrl_d;
  logic [IRQ_W-1:0] pend_q, pend_d;

  assign pend_q = sr_q[PEND_LSB +: IRQ_W];
  // clear wins over a raise in the same cycle
  assign pend_d = (pend_q | pend_set_i) & ~pend_clr_i;

  always_comb begin
    ctrl_d = wr_i ? (wdata_i & WMASK) : (sr_q & WMASK);
    if (trap_i) begin
      ctrl_d[ST_SUP]  = 1'b1;
      ctrl_d[ST_PSUP] = sr_q[ST_SUP];
      ctrl_d[ST_IE]   = 1'b0;
      ctrl_d[ST_PIE]  = sr_q[ST_IE];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= RST_VAL;
    else         sr_q <= ctrl_d | (SR_W'(pend_d) << PEND_LSB);
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/priv_ctrl.sv
module priv_ctrl
  import priv_pkg::*;
#(
  parameter int          XLEN     = 64,
  parameter bit          HAS_64   = 1'b1,
  parameter bit          HAS_FPU  = 1'b1,
  parameter bit          HAS_VEC  = 1'b0,
  parameter int          PEND_LSB = 24,
  parameter int          PG_BITS  = 13,
  parameter int          CNT_W    = 32,
  parameter int          INC_W    = 4,
  parameter int          HART_IDX = 3,
  parameter logic [63:0] RESET_PC = 64'h2000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [4:0]       acc_idx_i,
  input  logic             acc_rd_i,
  input  logic             acc_wr_i,
  input  logic [XLEN-1:0]  acc_wdata_i,
  output logic [XLEN-1:0]  acc_rdata_o,
  input  logic [INC_W-1:0] cnt_inc_i,
  input  logic             ipi_set_i,
  input  logic             pc_adv_i,
  input  logic [XLEN-1:0]  npc_i,
  output logic [XLEN-1:0]  pc_o,
  input  logic             exc_valid_i,
  input  logic [XLEN-1:0]  exc_cause_i,
  input  logic [XLEN-1:0]  exc_pc_i,
  input  logic             exc_badaddr_valid_i,
  input  logic [XLEN-1:0]  exc_badaddr_i,
  output logic             trap_taken_o,
  output logic [XLEN-1:0]  trap_cause_o,
  output logic             resv_release_o,
  output logic             tlb_flush_o,
  output logic             ipi_send_o,
  output logic [XLEN-1:0]  ipi_send_data_o,
  output logic [XLEN-1:0]  tohost_o
);
  localparam int SEL_W = $clog2(IRQ_W);
  localparam logic [XLEN-1:0] PG_MASK = ~((XLEN'(1) << PG_BITS) - XLEN'(1));

  logic [SR_W-1:0]  sr_q;
  logic [XLEN-1:0]  pc_q, epc_q, badaddr_q, evec_q, cause_q, ptbr_q;
  logic [XLEN-1:0]  scr0_q, scr1_q, tohost_q, fromhost_q;
  logic [CNT_W-1:0] count_w, cmp_w;
  logic             timer_fire;
  logic [IRQ_W-1:0] pend_set, pend_clr, irq_req;
  logic             irq_valid;
  logic [SEL_W-1:0] irq_sel;
  logic [XLEN-1:0]  irq_cause, trap_epc;

  logic wr_sr, wr_epc, wr_tvec, wr_cnt, wr_cmp, wr_ptb, wr_s0, wr_s1;
  logic wr_send, wr_iclr, wr_th, wr_fh;

  assign wr_sr   = acc_wr_i && (acc_idx_i == IDX_STATUS);
  assign wr_epc  = acc_wr_i && (acc_idx_i == IDX_EPC);
  assign wr_tvec = acc_wr_i && (acc_idx_i == IDX_TVEC);
  assign wr_cnt  = acc_wr_i && (acc_idx_i == IDX_COUNT);
  assign wr_cmp  = acc_wr_i && (acc_idx_i == IDX_CMP);
  assign wr_ptb  = acc_wr_i && (acc_idx_i == IDX_PTBASE);
  assign wr_s0   = acc_wr_i && (acc_idx_i == IDX_SCR0);
  assign wr_s1   = acc_wr_i && (acc_idx_i == IDX_SCR1);
  assign wr_send = acc_wr_i && (acc_idx_i == IDX_IPI_SEND);
  assign wr_iclr = acc_wr_i && (acc_idx_i == IDX_IPI_CLR);
  assign wr_th   = acc_wr_i && (acc_idx_i == IDX_TOHOST);
  assign wr_fh   = acc_wr_i && (acc_idx_i == IDX_FROMHOST);

  priv_timer #(.CNT_W(CNT_W), .INC_W(INC_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_wr_i  (wr_cnt),
    .cmp_wr_i  (wr_cmp),
    .wdata_i   (acc_wdata_i[CNT_W-1:0]),
    .inc_i     (cnt_inc_i),
    .count_o   (count_w),
    .compare_o (cmp_w),
    .fire_o    (timer_fire)
  );

  // pending sources
  always_comb begin
    pend_set = '0;
    pend_clr = '0;
    pend_set[IRQ_TIMER] = timer_fire;
    pend_clr[IRQ_TIMER] = wr_cmp;
    pend_set[IRQ_IPI]   = ipi_set_i || (wr_iclr && acc_wdata_i[0]);
    pend_clr[IRQ_IPI]   = wr_iclr && !acc_wdata_i[0];
    pend_set[IRQ_HOST]  = wr_fh && (acc_wdata_i != '0);
    pend_clr[IRQ_HOST]  = wr_fh && (acc_wdata_i == '0);
  end

  assign irq_req = sr_q[PEND_LSB +: IRQ_W] & sr_q[ST_MASK_LSB +: IRQ_W]
                 & {IRQ_W{sr_q[ST_IE]}};

  priv_irq_sel #(.N(IRQ_W)) u_sel (
    .req_i   (irq_req),
    .valid_o (irq_valid),
    .sel_o   (irq_sel)
  );

  always_comb begin
    irq_cause = XLEN'(irq_sel);
    if (XLEN > 32 && sr_q[ST_S64]) irq_cause[XLEN-1] = 1'b1;
    else                           irq_cause[31]     = 1'b1;
  end

  assign trap_taken_o   = exc_valid_i || irq_valid;
  assign trap_cause_o   = exc_valid_i ? exc_cause_i : irq_cause;
  assign trap_epc       = exc_valid_i ? exc_pc_i : pc_q;
  assign resv_release_o = trap_taken_o;

  priv_status #(
    .HAS_64(HAS_64), .HAS_FPU(HAS_FPU), .HAS_VEC(HAS_VEC), .PEND_LSB(PEND_LSB)
  ) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_sr),
    .wdata_i    (acc_wdata_i[SR_W-1:0]),
    .pend_set_i (pend_set),
    .pend_clr_i (pend_clr),
    .trap_i     (trap_taken_o),
    .sr_o       (sr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= RESET_PC[XLEN-1:0];
      epc_q      <= '0;
      badaddr_q  <= '0;
      evec_q     <= '0;
      cause_q    <= '0;
      ptbr_q     <= '0;
      scr0_q     <= '0;
      scr1_q     <= '0;
      tohost_q   <= '0;
      fromhost_q <= '0;
    end else begin
      if (trap_taken_o)  pc_q <= evec_q;
      else if (pc_adv_i) pc_q <= npc_i;
      if (trap_taken_o) begin
        epc_q   <= trap_epc;
        cause_q <= trap_cause_o;
      end else if (wr_epc) begin
        epc_q <= acc_wdata_i;
      end
      if (exc_valid_i && exc_badaddr_valid_i) badaddr_q <= exc_badaddr_i;
      if (wr_tvec) evec_q <= acc_wdata_i;
      if (wr_ptb)  ptbr_q <= acc_wdata_i & PG_MASK;
      if (wr_s0)   scr0_q <= acc_wdata_i;
      if (wr_s1)   scr1_q <= acc_wdata_i;
      if (wr_th && tohost_q == '0) tohost_q <= acc_wdata_i;
      if (wr_fh)   fromhost_q <= acc_wdata_i;
    end
  end

  always_comb begin
    case (acc_idx_i)
      IDX_STATUS:   acc_rdata_o = XLEN'(sr_q);
      IDX_EPC:      acc_rdata_o = epc_q;
      IDX_BADADDR:  acc_rdata_o = badaddr_q;
      IDX_TVEC:     acc_rdata_o = evec_q;
      IDX_COUNT:    acc_rdata_o = XLEN'(count_w);
      IDX_CMP:      acc_rdata_o = XLEN'(cmp_w);
      IDX_CAUSE:    acc_rdata_o = cause_q;
      IDX_PTBASE:   acc_rdata_o = ptbr_q;
      IDX_ASID:     acc_rdata_o = '0;
      IDX_FLUSHRD:  acc_rdata_o = '0;
      IDX_HART:     acc_rdata_o = XLEN'(HART_IDX);
      IDX_IMPL:     acc_rdata_o = XLEN'(1);
      IDX_SCR0:     acc_rdata_o = scr0_q;
      IDX_SCR1:     acc_rdata_o = scr1_q;
      IDX_TOHOST:   acc_rdata_o = tohost_q;
      IDX_FROMHOST: acc_rdata_o = fromhost_q;
      default:      acc_rdata_o = '1;
    endcase
  end

  assign tlb_flush_o     = wr_sr || (acc_rd_i && acc_idx_i == IDX_FLUSHRD);
  assign ipi_send_o      = wr_send;
  assign ipi_send_data_o = acc_wdata_i;
  assign pc_o            = pc_q;
  assign tohost_o        = tohost_q;
endmodule

// File: rtl/priv_ctrl_chk.sv
module priv_ctrl_chk
  import priv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trap_taken_o,
  input logic [XLEN-1:0]  trap_cause_o,
  input logic             exc_valid_i,
  input logic [XLEN-1:0]  exc_cause_i,
  input logic [XLEN-1:0]  pc_o,
  input logic [XLEN-1:0]  evec_q,
  input logic [SR_W-1:0]  sr_q,
  input logic [XLEN-1:0]  tohost_q
);
  // R5
  trap_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_taken_o |=> (sr_q[ST_SUP] && !sr_q[ST_IE]));

  // R5
  trap_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_taken_o |=> (pc_o == $past(evec_q)));

  // R6
  exc_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |-> (trap_taken_o && trap_cause_o == exc_cause_i));

  // R4
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_taken_o && !exc_valid_i) |-> (trap_cause_o[XLEN-1] || trap_cause_o[31]));

  // R9
  tohost_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tohost_q != '0) |=> (tohost_q == $past(tohost_q)));
endmodule

bind priv_ctrl priv_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trap_taken_o (trap_taken_o),
  .trap_cause_o (trap_cause_o),
  .exc_valid_i  (exc_valid_i),
  .exc_cause_i  (exc_cause_i),
  .pc_o         (pc_o),
  .evec_q       (evec_q),
  .sr_q         (sr_q),
  .tohost_q     (tohost_q)
);

// File: tb/priv_ctrl_tb.sv
module priv_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  acc_idx_i = '0;
  logic        acc_rd_i = 1'b0, acc_wr_i = 1'b0;
  logic [63:0] acc_wdata_i = '0, acc_rdata_o;
  logic [3:0]  cnt_inc_i = '0;
  logic        ipi_set_i = 1'b0, pc_adv_i = 1'b0;
  logic [63:0] npc_i = '0, pc_o;
  logic        exc_valid_i = 1'b0, exc_badaddr_valid_i = 1'b0;
  logic [63:0] exc_cause_i = '0, exc_pc_i = '0, exc_badaddr_i = '0;
  logic        trap_taken_o, resv_release_o, tlb_flush_o, ipi_send_o;
  logic [63:0] trap_cause_o, ipi_send_data_o, tohost_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  priv_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [63:0] d,
                    output logic [63:0] old, output logic fl);
    @(negedge clk_i);
    acc_idx_i = idx; acc_wdata_i = d; acc_wr_i = 1'b1;
    #1 old = acc_rdata_o; fl = tlb_flush_o;
    @(negedge clk_i);
    acc_wr_i = 1'b0; acc_wdata_i = '0;
  endtask

  task automatic rd(input logic [4:0] idx, output logic [63:0] v, output logic fl);
    @(negedge clk_i);
    acc_idx_i = idx; acc_rd_i = 1'b1;
    #1 v = acc_rdata_o; fl = tlb_flush_o;
    acc_rd_i = 1'b0;
  endtask

  function automatic logic [63:0] rdv(input logic [4:0] idx);
    return 64'(idx);
  endfunction

  task automatic t_reset();
    logic [63:0] v; logic fl;
    chk("R1 pc", pc_o, 64'h2000);
    chk("R1 trap", 64'(trap_taken_o), 64'h0);
    rd(5'd0, v, fl); chk("R1 status", v, 64'h81);
    rd(5'd1, v, fl); chk("R1 epc", v, 0);
    rd(5'd3, v, fl); chk("R1 tvec", v, 0);
    rd(5'd4, v, fl); chk("R1 count", v, 0);
    rd(5'd6, v, fl); chk("R1 cause", v, 0);
  endtask

  task automatic t_status();
    logic [63:0] v, old; logic fl;
    wr(5'd0, 64'hFFFF_FFFF_FFFF_FFFF, old, fl);
    chk("R12 old status", old, 64'h81);
    chk("R2 flush", 64'(fl), 1);
    rd(5'd0, v, fl); chk("R2 masked status", v, 64'h00FF_00DF);
    chk("R2 no flush on read", 64'(fl), 0);
    wr(5'd0, 64'h81, old, fl);
  endtask

  task automatic t_fixed();
    logic [63:0] v, old; logic fl;
    rd(5'd8, v, fl);  chk("R11 asid", v, 0);
    rd(5'd11, v, fl); chk("R11 impl", v, 1);
    rd(5'd10, v, fl); chk("R11 hart", v, 3);
    rd(5'd9, v, fl);  chk("R11 flush read value", v, 0);
    chk("R11 flush on read", 64'(fl), 1);
    rd(5'd31, v, fl); chk("R11 unknown", v, '1);
    wr(5'd7, 64'hFFFF, old, fl);
    rd(5'd7, v, fl); chk("R8 ptbase", v, 64'hE000);
    wr(5'd12, 64'h55, old, fl);
    wr(5'd12, 64'h66, old, fl); chk("R12 scratch old", old, 64'h55);
  endtask

  task automatic t_host();
    logic [63:0] v, old; logic fl;
    wr(5'd16, 64'h5, old, fl);
    wr(5'd16, 64'h9, old, fl); chk("R12 tohost old", old, 64'h5);
    rd(5'd16, v, fl); chk("R9 tohost held", v, 64'h5);
    chk("R9 tohost port", tohost_o, 64'h5);
    wr(5'd17, 64'h10, old, fl);
    rd(5'd17, v, fl); chk("R10 fromhost value", v, 64'h10);
    rd(5'd0, v, fl);  chk("R10 host pending", v, 64'h0400_0081);
    wr(5'd17, 64'h0, old, fl);
    rd(5'd0, v, fl);  chk("R10 host cleared", v, 64'h81);
  endtask

  task automatic t_timer();
    logic [63:0] v, old; logic fl;
    wr(5'd5, 64'd5, old, fl);
    @(negedge clk_i); cnt_inc_i = 4'd3;
    @(negedge clk_i); cnt_inc_i = 4'd0;
    rd(5'd0, v, fl); chk("R7 no raise below compare", v, 64'h81);
    @(negedge clk_i); cnt_inc_i = 4'd3;
    @(negedge clk_i); cnt_inc_i = 4'd0;
    rd(5'd4, v, fl); chk("R7 count", v, 64'd6);
    rd(5'd0, v, fl); chk("R7 raise on crossing", v, 64'h0100_0081);
    wr(5'd5, 64'd100, old, fl);
    rd(5'd0, v, fl); chk("R7 compare write clears", v, 64'h81);
  endtask

  task automatic t_irq();
    logic [63:0] v, old; logic fl;
    wr(5'd15, 64'h1, old, fl);
    rd(5'd0, v, fl); chk("R8 ipi set", v, 64'h0200_0081);
    wr(5'd0, 64'hFF00_0081, old, fl);
    rd(5'd0, v, fl); chk("R2 pending kept", v, 64'h0200_0081);
    chk("R3 no trap while disabled", 64'(trap_taken_o), 0);
    wr(5'd17, 64'h1, old, fl);
    wr(5'd3, 64'h400, old, fl);
    wr(5'd0, 64'h0006_0085, old, fl);
    #1;
    chk("R3 trap taken", 64'(trap_taken_o), 1);
    chk("R3 R4 lowest cause bit63", trap_cause_o, 64'h8000_0000_0000_0001);
    chk("R5 reservation release", 64'(resv_release_o), 1);
    rd(5'd0, v, fl); chk("R5 status shadows", v, 64'h0606_008B);
    chk("R5 pc from vector", pc_o, 64'h400);
    rd(5'd1, v, fl); chk("R5 epc", v, 64'h2000);
    rd(5'd6, v, fl); chk("R5 cause", v, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_exc();
    logic [63:0] v, old; logic fl;
    wr(5'd0, 64'h0006_0085, old, fl);
    exc_valid_i = 1'b1; exc_cause_i = 64'd7; exc_pc_i = 64'h1234;
    exc_badaddr_valid_i = 1'b1; exc_badaddr_i = 64'hBAD;
    #1;
    chk("R6 exception cause wins", trap_cause_o, 64'd7);
    @(negedge clk_i);
    exc_valid_i = 1'b0; exc_badaddr_valid_i = 1'b0;
    rd(5'd1, v, fl); chk("R6 epc", v, 64'h1234);
    rd(5'd6, v, fl); chk("R6 cause", v, 64'd7);
    rd(5'd2, v, fl); chk("R6 badaddr", v, 64'hBAD);
    wr(5'd0, 64'h0006_0005, old, fl);
    #1;
    chk("R4 cause bit31", trap_cause_o, 64'h0000_0000_8000_0001);
    wr(5'd14, 64'h42, old, fl);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_status();
    t_fixed();
    t_host();
    t_timer();
    t_irq();
    t_exc();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule